// File: doc/BRIEF.md
# Dual-Master Transfer Request Front End

This block connects two local bus masters to the engine that runs cycles on the system bus. Each master has its own handshake: a request input, a grant output, a ready input and a select output. When one or both masters request, the block picks one of them in round-robin order and raises a system-bus request. It returns that master's grant only after the engine reports that the bus is owned.

The granted master then presents its cycle attributes on shared active-low inputs and pulses ready: two width bits, two space bits and a write/read bit. The block latches the attributes and drives them for one cycle, the request phase, on a five-bit active-low system-control output with an enable. After that it follows the data phase. The granted master's burst-last input appears on an end-of-cycle output. A completion pulse from the engine on a beat with last high ends the cycle. A locked cycle whose master still requests keeps both bus ownership and the grant for a back-to-back transfer.

Top module: `lrq_front`

## Requirements
- R1: After synchronous reset, no grant or select is high, bus_req_o, sc_oe_o, eoc_o and lock_o are low and sc_n_o is all ones.
- R2: A request from an idle block raises bus_req_o. A grant rises only in the cycle after bus_own_i was seen high.
- R3: At most one grant is high at a time. When both masters request together, the one not served last wins, and master 0 wins first after reset.
- R4: Attributes are latched on the clock edge where the granted master's rdy_i bit is high. A ready from the master without grant has no effect and starts no request phase.
- R5: One cycle after latching, sc_oe_o is high for exactly one cycle with sc_n_o = {wid_n_i[1], wid_n_i[0], spc_n_i[1], spc_n_i[0], wr_n_i} (bit 4 down to bit 0) as latched.
- R6: Whenever sc_oe_o is low, sc_n_o is all ones.
- R7: sel_o[i] is high exactly during the request phase of master i, and only while grant_o[i] is high.
- R8: In the data phase eoc_o follows the granted master's last_i bit. xfer_done_i with last low keeps the burst going, and xfer_done_i with last high ends the cycle.
- R9: lock_o is high from the request phase until the cycle ends when the latched lock bit was set. If the cycle ends while that master still requests, its grant stays high and the other master gets no grant.
- R10: When an unlocked cycle ends, the grant and bus_req_o are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Per-master transfer request |
| rdy_i | input | 2 | Per-master attributes-valid strobe |
| wid_n_i | input | 2 | Active-low data width code |
| spc_n_i | input | 2 | Active-low address space code |
| wr_n_i | input | 1 | Active-low write (high = read) |
| last_i | input | 2 | Per-master burst last-beat flag |
| lock_i | input | 2 | Per-master locked-cycle flag |
| bus_own_i | input | 1 | System bus is owned |
| xfer_done_i | input | 1 | Engine completed one data beat |
| grant_o | output | 2 | Per-master grant |
| sel_o | output | 2 | Per-master request-phase select |
| bus_req_o | output | 1 | System bus request |
| sc_n_o | output | 5 | Active-low request-phase control word |
| sc_oe_o | output | 1 | Drive enable for sc_n_o |
| eoc_o | output | 1 | End-of-cycle indication |
| lock_o | output | 1 | Locked cycle in progress |

## Verification
A corrupted owner register shows as the wrong grant or select bit within one cycle of the grant. A bad arbitration pointer shows only on the next contended request. Faulty attribute latching shows as a wrong control word in the single request-phase cycle, so the monitor compares every request phase against a queued expectation. A state machine stuck in the data phase or wrongly kept in ownership appears at the first cycle end, as a grant or bus request that stays high after an unlocked final beat.

// File: rtl/lrq_pkg.sv
package lrq_pkg;

    localparam int N_MST    = 2;
    localparam int IDX_W    = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam int WID_BITS = 2;
    localparam int SPC_BITS = 2;
    localparam int SC_W     = WID_BITS + SPC_BITS + 1;

    typedef struct packed {
        logic [WID_BITS-1:0] wid_n;
        logic [SPC_BITS-1:0] spc_n;
        logic                wr_n;
    } lrq_attr_t;

    typedef struct packed {
        lrq_attr_t attr;
        logic      lock;
    } lrq_cap_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BUSWAIT = 3'd1,
        ST_GRANT   = 3'd2,
        ST_REQ     = 3'd3,
        ST_DATA    = 3'd4
    } lrq_state_e;

    function automatic logic [IDX_W-1:0] rr_pick(input logic [N_MST-1:0] req,
                                                 input logic [IDX_W-1:0] ptr);
        logic [IDX_W-1:0] sel;
        logic             found;
        sel   = ptr;
        found = 1'b0;
        for (int k = 0; k < N_MST; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N_MST;
            if (!found && req[idx]) begin
                sel   = IDX_W'(idx);
                found = 1'b1;
            end
        end
        return sel;
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] cur);
        return IDX_W'((int'(cur) + 1) % N_MST);
    endfunction

    function automatic logic [SC_W-1:0] attr_word(input lrq_attr_t a);
        return {a.wid_n, a.spc_n, a.wr_n};
    endfunction

endpackage

// File: rtl/lrq_arb.sv
module lrq_arb
    import lrq_pkg::*;
#(
    parameter int N = N_MST
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 pick_en,
    input  logic                 release_en,
    output logic [IDX_W-1:0]     owner,
    output logic                 any_req
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] owner_q;

    assign any_req = |req;
    assign owner   = owner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            owner_q <= '0;
        end else begin
            if (pick_en)
                owner_q <= rr_pick(req, ptr_q);
            if (release_en)
                ptr_q <= next_idx(owner_q);
        end
    end
endmodule

// File: rtl/lrq_cap.sv
module lrq_cap
    import lrq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  lrq_cap_t d,
    output lrq_cap_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.attr <= '1;
            q.lock <= 1'b0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lrq_seq.sv
module lrq_seq
    import lrq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_req,
    input  logic       bus_own,
    input  logic       rdy_own,
    input  logic       done,
    input  logic       last_own,
    input  logic       lock_held,
    input  logic       req_own,
    output lrq_state_e state,
    output logic       pick_en,
    output logic       load_en,
    output logic       release_en
);
    lrq_state_e state_d;
    logic       keep;

    assign keep       = lock_held && req_own;
    assign pick_en    = (state == ST_IDLE) && any_req;
    assign load_en    = (state == ST_GRANT) && rdy_own;
    assign release_en = (state == ST_DATA) && done && last_own && !keep;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (any_req) state_d = ST_BUSWAIT;
            ST_BUSWAIT: if (bus_own) state_d = ST_GRANT;
            ST_GRANT:   if (rdy_own) state_d = ST_REQ;
            ST_REQ:     state_d = ST_DATA;
            ST_DATA:    if (done && last_own) state_d = keep ? ST_GRANT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/lrq_front.sv
module lrq_front
    import lrq_pkg::*;
#(
    parameter int N  = N_MST,
    parameter int WB = WID_BITS,
    parameter int SB = SPC_BITS,
    localparam int SCW = WB + SB + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   req_i,
    input  logic [N-1:0]   rdy_i,
    input  logic [WB-1:0]  wid_n_i,
    input  logic [SB-1:0]  spc_n_i,
    input  logic           wr_n_i,
    input  logic [N-1:0]   last_i,
    input  logic [N-1:0]   lock_i,
    input  logic           bus_own_i,
    input  logic           xfer_done_i,
    output logic [N-1:0]   grant_o,
    output logic [N-1:0]   sel_o,
    output logic           bus_req_o,
    output logic [SCW-1:0] sc_n_o,
    output logic           sc_oe_o,
    output logic           eoc_o,
    output logic           lock_o
);
    logic [IDX_W-1:0] owner;
    logic             any_req, pick_en, load_en, release_en;
    lrq_state_e       state;
    lrq_cap_t         cap_d, cap_q;
    logic             owning, in_req, in_data;

    lrq_arb #(.N(N)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .pick_en    (pick_en),
        .release_en (release_en),
        .owner      (owner),
        .any_req    (any_req)
    );

    lrq_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .any_req    (any_req),
        .bus_own    (bus_own_i),
        .rdy_own    (rdy_i[owner]),
        .done       (xfer_done_i),
        .last_own   (last_i[owner]),
        .lock_held  (cap_q.lock),
        .req_own    (req_i[owner]),
        .state      (state),
        .pick_en    (pick_en),
        .load_en    (load_en),
        .release_en (release_en)
    );

    assign cap_d.attr.wid_n = wid_n_i;
    assign cap_d.attr.spc_n = spc_n_i;
    assign cap_d.attr.wr_n  = wr_n_i;
    assign cap_d.lock       = lock_i[owner];

    lrq_cap u_cap (
        .clk  (clk),
        .rst  (rst),
        .load (load_en),
        .d    (cap_d),
        .q    (cap_q)
    );

    assign owning  = (state == ST_GRANT) || (state == ST_REQ) || (state == ST_DATA);
    assign in_req  = (state == ST_REQ);
    assign in_data = (state == ST_DATA);

    generate
        for (genvar g = 0; g < N; g++) begin : g_mst
            assign grant_o[g] = owning && (owner == IDX_W'(g));
            assign sel_o[g]   = in_req && (owner == IDX_W'(g));
        end
    endgenerate

    assign bus_req_o = (state != ST_IDLE);
    assign sc_oe_o   = in_req;
    assign sc_n_o    = in_req ? attr_word(cap_q.attr) : '1;
    assign eoc_o     = in_data && last_i[owner];
    assign lock_o    = (in_req || in_data) && cap_q.lock;
endmodule

// File: rtl/lrq_front_chk.sv
module lrq_front_chk #(
    parameter int N   = 2,
    parameter int SCW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   req_i,
    input logic           bus_own_i,
    input logic           xfer_done_i,
    input logic [N-1:0]   grant_o,
    input logic [N-1:0]   sel_o,
    input logic           bus_req_o,
    input logic [SCW-1:0] sc_n_o,
    input logic           sc_oe_o,
    input logic           eoc_o,
    input logic           lock_o
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R3

    AST_GRANT_AFTER_OWN: assert property (@(posedge clk) disable iff (rst)
        $rose(|grant_o) |-> $past(bus_own_i) && bus_req_o); // R2

    AST_SC_IDLE_ONES: assert property (@(posedge clk) disable iff (rst)
        !sc_oe_o |-> (sc_n_o == '1)); // R6

    AST_REQ_PHASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sc_oe_o |=> !sc_oe_o); // R5

    AST_SEL_UNDER_GRANT: assert property (@(posedge clk) disable iff (rst)
        ((sel_o & ~grant_o) == '0) && ((|sel_o) == sc_oe_o)); // R7

    AST_LOCK_KEEPS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (lock_o && eoc_o && xfer_done_i && |(req_i & grant_o)) |=> (grant_o == $past(grant_o))); // R9

    AST_UNLOCKED_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!lock_o && eoc_o && xfer_done_i) |=> (!bus_req_o && grant_o == '0)); // R10
endmodule

bind lrq_front lrq_front_chk #(.N(N), .SCW(SCW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .bus_own_i   (bus_own_i),
    .xfer_done_i (xfer_done_i),
    .grant_o     (grant_o),
    .sel_o       (sel_o),
    .bus_req_o   (bus_req_o),
    .sc_n_o      (sc_n_o),
    .sc_oe_o     (sc_oe_o),
    .eoc_o       (eoc_o),
    .lock_o      (lock_o)
);

// File: tb/lrq_front_test.sv
module lrq_front_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] req_i = '0, rdy_i = '0, last_i = '0, lock_i = '0;
    logic [1:0] wid_n_i = '1, spc_n_i = '1;
    logic       wr_n_i = 1'b1, bus_own_i = 1'b0, xfer_done_i = 1'b0;
    logic [1:0] grant_o, sel_o;
    logic       bus_req_o, sc_oe_o, eoc_o, lock_o;
    logic [4:0] sc_n_o;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { int m; logic [4:0] word; } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) bus_own_i <= rst ? 1'b0 : bus_req_o;

    lrq_front uut (
        .clk(clk), .rst(rst), .req_i(req_i), .rdy_i(rdy_i),
        .wid_n_i(wid_n_i), .spc_n_i(spc_n_i), .wr_n_i(wr_n_i),
        .last_i(last_i), .lock_i(lock_i), .bus_own_i(bus_own_i),
        .xfer_done_i(xfer_done_i), .grant_o(grant_o), .sel_o(sel_o),
        .bus_req_o(bus_req_o), .sc_n_o(sc_n_o), .sc_oe_o(sc_oe_o),
        .eoc_o(eoc_o), .lock_o(lock_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: every request phase is compared against the scoreboard
    always @(negedge clk) begin
        if (!rst && sc_oe_o) begin
            if (sb_q.size() == 0) begin
                check("R5 unexpected request phase", 32'(sc_n_o), 32'h1f);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R5 request-phase word", 32'(sc_n_o), 32'(e.word));
                check("R7 select", 32'(sel_o), 32'(2'b01 << e.m));
            end
        end
    end

    task automatic wait_grant(input int m);
        int guard = 0;
        while (!grant_o[m] && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check("R2 grant reached", 32'(grant_o[m]), 32'd1);
        check("R3 single grant", 32'(grant_o), 32'(2'b01 << m));
    endtask

    // drive one transfer of a granted master: ready, request phase, data beats
    task automatic xfer(input int m, input logic [1:0] w, input logic [1:0] s,
                        input logic wr, input logic lk, input int beats);
        exp_t e;
        wid_n_i = w; spc_n_i = s; wr_n_i = wr;
        lock_i[m] = lk;
        rdy_i[m] = 1'b1;
        e.m = m; e.word = {w[1], w[0], s[1], s[0], wr};
        sb_q.push_back(e);
        @(negedge clk);                       // request phase visible here
        rdy_i[m] = 1'b0;
        wid_n_i = ~w; spc_n_i = ~s; wr_n_i = ~wr;   // changes after capture must not matter
        check("R9 lock during request", 32'(lock_o), 32'(lk));
        @(negedge clk);                       // data phase
        for (int b = 0; b < beats; b++) begin
            last_i[m] = (b == beats - 1);
            xfer_done_i = 1'b1;
            #1;
            check("R8 end-of-cycle follows last", 32'(eoc_o), 32'(b == beats - 1));
            @(negedge clk);
            xfer_done_i = 1'b0;
            last_i[m] = 1'b0;
        end
        lock_i[m] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 grant", 32'(grant_o), 32'd0);
        check("R1 sel", 32'(sel_o), 32'd0);
        check("R1 bus_req", 32'(bus_req_o), 32'd0);
        check("R1 sc word", 32'(sc_n_o), 32'h1f);
        check("R1 sc_oe/eoc/lock", 32'({sc_oe_o, eoc_o, lock_o}), 32'd0);
        rst = 1'b0;

        // R3: both request at once, master 0 first after reset
        req_i = 2'b11;
        @(negedge clk);
        check("R2 bus request raised", 32'(bus_req_o), 32'd1);
        check("R2 no grant before ownership", 32'(grant_o), 32'd0);
        wait_grant(0);

        // R4: ready from the other master is ignored
        rdy_i[1] = 1'b1;
        @(negedge clk);
        rdy_i[1] = 1'b0;
        check("R4 foreign ready ignored oe", 32'(sc_oe_o), 32'd0);
        check("R4 still granted", 32'(grant_o), 32'b01);

        // R5/R6/R8 single-beat unlocked transfer
        xfer(0, 2'b10, 2'b01, 1'b0, 1'b0, 1);
        check("R10 grant released", 32'(grant_o), 32'd0);
        check("R10 bus request dropped", 32'(bus_req_o), 32'd0);
        check("R6 idle word", 32'(sc_n_o), 32'h1f);

        // R3 round robin: master 1 next; R8 burst of three beats
        wait_grant(1);
        xfer(1, 2'b01, 2'b10, 1'b1, 1'b0, 3);
        req_i[1] = 1'b0;
        check("R10 released after burst", 32'(bus_req_o), 32'd0);

        // R9 locked transfer keeps the grant while other master waits
        req_i = 2'b11;
        wait_grant(0);
        xfer(0, 2'b00, 2'b11, 1'b0, 1'b1, 2);
        check("R9 grant kept", 32'(grant_o), 32'b01);
        check("R9 bus kept", 32'(bus_req_o), 32'd1);
        @(negedge clk);
        check("R9 other master held off", 32'(grant_o), 32'b01);
        xfer(0, 2'b11, 2'b00, 1'b1, 1'b0, 1);
        req_i[0] = 1'b0;
        check("R10 unlocked end releases", 32'(grant_o), 32'd0);
        wait_grant(1);
        xfer(1, 2'b10, 2'b10, 1'b0, 1'b0, 1);
        req_i = 2'b00;

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 32'(sb_q.size()), 32'd0);
        check("R1 quiet at end", 32'({bus_req_o, grant_o}), 32'd0);
        finish_run();
    end
endmodule